// File: doc/BRIEF.md
# Bit-Manipulation ALU

This block computes one bit-manipulation result per cycle from two XLEN-bit operands, a shift amount and a 5-bit operation code. It covers single-bit set, clear, invert and extract, ones-filling shifts, scaled adds with their unsigned-word forms, the half, halfword and byte packing operations, leading-zero, trailing-zero and population counts at full and 32-bit width, 32-bit rotates and a full byte reverse. It is meant to sit beside the integer ALU of a processor pipeline. Selection is by operation code and the result is merged onto a single output bus.

The shift amount comes either from the low bits of operand B (register form) or from a separate immediate input (immediate form). The datapath is combinational. An output register, chosen by parameter and on by default, adds one cycle of latency and clears on a synchronous active-high reset.

Top module: `bitmanip_alu`

## Requirements
- R1: With the output register on, `res_o` reads zero while `rst_i` is high. The result for inputs applied before a rising edge shows on `res_o` right after that edge.
- R2: Codes 1, 2 and 3 return A with bit `s` set, cleared or inverted. Code 4 returns bit `s` of A in bit 0, with all other bits zero. Here `s` is the shift amount taken modulo XLEN.
- R3: Code 5 shifts A left by `s` and fills the vacated low bits with ones. Code 6 shifts A right by `s` and fills the vacated high bits with ones.
- R4: Codes 7, 8 and 9 return (A<<1)+B, (A<<2)+B and (A<<3)+B. Codes 10, 11 and 12 do the same after zero-extending A[31:0]. Code 13 returns zero-extended A[31:0] plus B.
- R5: Code 14 returns {B low half, A low half}. Code 15 returns {B high half, A high half}. Code 16 returns B[7:0] in bits 15:8 and A[7:0] in bits 7:0, with all higher bits zero.
- R6: Code 17 returns A[15:0] in bits 15:0 and B[15:0] in bits 31:16, and fills bits above 31 with B[15]. Code 18 forms {B[31:16], A[31:16]} and sign-extends it from bit 31.
- R7: Codes 19, 20 and 21 return the leading-zero count, trailing-zero count and number of set bits of A over XLEN bits. A zero A gives XLEN for codes 19 and 20.
- R8: Codes 22, 23 and 24 return the same three counts over A[31:0] only. A zero A[31:0] gives 32 for codes 22 and 23.
- R9: Codes 25 and 26 rotate A[31:0] left or right by the shift amount modulo 32, and sign-extend the 32-bit result from bit 31.
- R10: Code 27 returns A with its bytes in reverse order.
- R11: When `amt_sel_i` is 1 the shift amount is `amt_imm_i`, and B's low bits have no effect. When it is 0 the shift amount is B[log2(XLEN)-1:0], and `amt_imm_i` has no effect.
- R12: Code 0 and codes 28 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset of the output register |
| op_i | input | 5 | Operation code |
| a_i | input | XLEN | Operand A |
| b_i | input | XLEN | Operand B, also the register-form shift amount |
| amt_sel_i | input | 1 | 1 selects the immediate shift amount |
| amt_imm_i | input | log2(XLEN) | Immediate shift amount |
| res_o | output | XLEN | Result |

## Verification
With the default output register, every operation has a latency of exactly one cycle. The result for inputs set up before a rising edge is on `res_o` right after that edge. The bench changes inputs on the falling edge and compares `res_o` with its behavioural model on the next falling edge, so each sample lands half a period after the edge that captured it. During reset the output is sampled on the same falling-edge grid and must read zero.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    typedef enum logic [4:0] {
        OP_NONE     = 5'd0,
        OP_BSET     = 5'd1,
        OP_BCLR     = 5'd2,
        OP_BINV     = 5'd3,
        OP_BEXT     = 5'd4,
        OP_SHL_ONES = 5'd5,
        OP_SHR_ONES = 5'd6,
        OP_SCADD1   = 5'd7,
        OP_SCADD2   = 5'd8,
        OP_SCADD3   = 5'd9,
        OP_SCADD1W  = 5'd10,
        OP_SCADD2W  = 5'd11,
        OP_SCADD3W  = 5'd12,
        OP_ADDW_U   = 5'd13,
        OP_PK_LO    = 5'd14,
        OP_PK_HI    = 5'd15,
        OP_PK_BYTE  = 5'd16,
        OP_PK_LO_W  = 5'd17,
        OP_PK_HI_W  = 5'd18,
        OP_LZC      = 5'd19,
        OP_TZC      = 5'd20,
        OP_POP      = 5'd21,
        OP_LZC_W    = 5'd22,
        OP_TZC_W    = 5'd23,
        OP_POP_W    = 5'd24,
        OP_ROTL_W   = 5'd25,
        OP_ROTR_W   = 5'd26,
        OP_BSWAP    = 5'd27
    } op_e;

    localparam int WORD = 32;

    function automatic logic op_known(input logic [4:0] code);
        return (code != 5'd0) && (code <= 5'd27);
    endfunction

endpackage

// File: rtl/bmu_bitsh.sv
module bmu_bitsh
    import bmu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SW = $clog2(XLEN)
) (
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [SW-1:0]   amt,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] onehot;
    logic [XLEN-1:0] a_zw;

    assign onehot = {{(XLEN-1){1'b0}}, 1'b1} << amt;
    assign a_zw   = {{(XLEN-WORD){1'b0}}, a[WORD-1:0]};

    always_comb begin
        case (op)
            OP_BSET:     res = a | onehot;
            OP_BCLR:     res = a & ~onehot;
            OP_BINV:     res = a ^ onehot;
            OP_BEXT:     res = {{(XLEN-1){1'b0}}, a[amt]};
            OP_SHL_ONES: res = ~((~a) << amt);
            OP_SHR_ONES: res = ~((~a) >> amt);
            OP_SCADD1:   res = (a << 1) + b;
            OP_SCADD2:   res = (a << 2) + b;
            OP_SCADD3:   res = (a << 3) + b;
            OP_SCADD1W:  res = (a_zw << 1) + b;
            OP_SCADD2W:  res = (a_zw << 2) + b;
            OP_SCADD3W:  res = (a_zw << 3) + b;
            OP_ADDW_U:   res = a_zw + b;
            default:     res = '0;
        endcase
    end
endmodule

// File: rtl/bmu_pack.sv
module bmu_pack
    import bmu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int HALF  = XLEN / 2,
    localparam int BYTES = XLEN / 8
) (
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [4:0]      rot,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0]   swapped;
    logic [2*WORD-1:0] dbl;
    logic [2*WORD-1:0] rol_t;
    logic [2*WORD-1:0] ror_t;
    logic [WORD-1:0]   hiw;

    for (genvar g = 0; g < BYTES; g++) begin : g_swap
        assign swapped[8*g +: 8] = a[8*(BYTES-1-g) +: 8];
    end

    assign dbl   = {a[WORD-1:0], a[WORD-1:0]};
    assign rol_t = dbl << rot;
    assign ror_t = dbl >> rot;
    assign hiw   = {b[WORD-1:16], a[WORD-1:16]};

    always_comb begin
        case (op)
            OP_PK_LO:   res = {b[HALF-1:0], a[HALF-1:0]};
            OP_PK_HI:   res = {b[XLEN-1:HALF], a[XLEN-1:HALF]};
            OP_PK_BYTE: res = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};
            OP_PK_LO_W: res = {{(XLEN-WORD){b[15]}}, b[15:0], a[15:0]};
            OP_PK_HI_W: res = {{(XLEN-WORD){hiw[WORD-1]}}, hiw};
            OP_ROTL_W:  res = {{(XLEN-WORD){rol_t[2*WORD-1]}}, rol_t[2*WORD-1:WORD]};
            OP_ROTR_W:  res = {{(XLEN-WORD){ror_t[WORD-1]}}, ror_t[WORD-1:0]};
            OP_BSWAP:   res = swapped;
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/bmu_count.sv
module bmu_count
    import bmu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int CW = $clog2(XLEN + 1)
) (
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    output logic [XLEN-1:0] res
);
    localparam logic [CW-1:0] WOFF = CW'(XLEN - WORD);

    function automatic logic [CW-1:0] trail(input logic [XLEN-1:0] v);
        logic [CW-1:0] n;
        n = CW'(XLEN);
        for (int i = XLEN - 1; i >= 0; i--)
            if (v[i]) n = CW'(i);
        return n;
    endfunction

    function automatic logic [CW-1:0] lead(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
        return trail(r);
    endfunction

    function automatic logic [CW-1:0] ones(input logic [XLEN-1:0] v);
        logic [CW-1:0] n;
        n = '0;
        for (int i = 0; i < XLEN; i++) n = n + CW'(v[i]);
        return n;
    endfunction

    logic [XLEN-1:0] a_zw;
    logic [XLEN-1:0] a_ow;
    logic [CW-1:0]   cnt;

    assign a_zw = {{(XLEN-WORD){1'b0}}, a[WORD-1:0]};
    assign a_ow = {{(XLEN-WORD){1'b1}}, a[WORD-1:0]};

    always_comb begin
        case (op)
            OP_LZC:   cnt = lead(a);
            OP_TZC:   cnt = trail(a);
            OP_POP:   cnt = ones(a);
            OP_LZC_W: cnt = lead(a_zw) - WOFF;
            OP_TZC_W: cnt = trail(a_ow);
            OP_POP_W: cnt = ones(a_zw);
            default:  cnt = '0;
        endcase
    end

    assign res = {{(XLEN-CW){1'b0}}, cnt};
endmodule

// File: rtl/bitmanip_alu.sv
module bitmanip_alu
    import bmu_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit OUT_REG = 1'b1,
    localparam int SW = $clog2(XLEN)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [4:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            amt_sel_i,
    input  logic [SW-1:0]   amt_imm_i,
    output logic [XLEN-1:0] res_o
);
    op_e             op;
    logic [SW-1:0]   amt;
    logic [XLEN-1:0] r_bit, r_pack, r_cnt, res_c;

    assign op  = op_e'(op_i);
    assign amt = amt_sel_i ? amt_imm_i : b_i[SW-1:0];

    bmu_bitsh #(.XLEN(XLEN)) u_bitsh (
        .op(op), .a(a_i), .b(b_i), .amt(amt), .res(r_bit)
    );

    bmu_pack #(.XLEN(XLEN)) u_pack (
        .op(op), .a(a_i), .b(b_i), .rot(amt[4:0]), .res(r_pack)
    );

    bmu_count #(.XLEN(XLEN)) u_count (
        .op(op), .a(a_i), .res(r_cnt)
    );

    // each unit drives zero outside its own codes
    assign res_c = r_bit | r_pack | r_cnt;

    if (OUT_REG) begin : g_reg
        logic [XLEN-1:0] res_q;
        logic            vld_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                res_q <= '0;
                vld_q <= 1'b0;
            end else begin
                res_q <= res_c;
                vld_q <= 1'b1;
            end
        end
        assign res_o = res_q;

        p_reset_clear_r1: assert property (@(posedge clk_i)
            rst_i |=> res_o == '0);

        p_unused_zero_r12: assert property (@(posedge clk_i) disable iff (rst_i)
            (vld_q && !op_known($past(op_i))) |-> res_o == '0);

        p_extract_bit_r2: assert property (@(posedge clk_i) disable iff (rst_i)
            (vld_q && $past(op) == OP_BEXT) |-> res_o[XLEN-1:1] == '0);

        p_packbyte_upper_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            (vld_q && $past(op) == OP_PK_BYTE) |-> res_o[XLEN-1:16] == '0);

        p_tzc_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
            (vld_q && $past(op) == OP_TZC && $past(a_i) == '0) |-> res_o == XLEN);

        p_word_count_range_r8: assert property (@(posedge clk_i) disable iff (rst_i)
            (vld_q && ($past(op) == OP_LZC_W || $past(op) == OP_TZC_W ||
                       $past(op) == OP_POP_W)) |-> res_o <= WORD);

        p_rotate_sext_r9: assert property (@(posedge clk_i) disable iff (rst_i)
            (vld_q && ($past(op) == OP_ROTL_W || $past(op) == OP_ROTR_W)) |->
            ($countones(res_o[XLEN-1:WORD-1]) == 0 ||
             $countones(res_o[XLEN-1:WORD-1]) == XLEN - WORD + 1));
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk_i ^ rst_i;
        assign res_o = res_c;
    end
endmodule

// File: tb/bitmanip_alu_tb.sv
`timescale 1ns/1ps
module bitmanip_alu_tb;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [4:0]      op  = '0;
    logic [XLEN-1:0] a   = '0;
    logic [XLEN-1:0] b   = '0;
    logic            sel = 1'b0;
    logic [5:0]      imm = '0;
    logic [XLEN-1:0] res;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bitmanip_alu #(.XLEN(XLEN)) u_dut (
        .clk_i(clk), .rst_i(rst), .op_i(op), .a_i(a), .b_i(b),
        .amt_sel_i(sel), .amt_imm_i(imm), .res_o(res)
    );

    function automatic string tag_of(input int code);
        if (code >= 1 && code <= 4)   return "R2";
        if (code == 5 || code == 6)   return "R3";
        if (code >= 7 && code <= 13)  return "R4";
        if (code >= 14 && code <= 16) return "R5";
        if (code == 17 || code == 18) return "R6";
        if (code >= 19 && code <= 21) return "R7";
        if (code >= 22 && code <= 24) return "R8";
        if (code == 25 || code == 26) return "R9";
        if (code == 27)               return "R10";
        return "R12";
    endfunction

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] model(input int code, input logic [63:0] x,
                                          input logic [63:0] y, input logic s_sel,
                                          input logic [5:0] s_imm);
        int s;
        int n;
        logic [63:0] r;
        logic [31:0] w;
        s = s_sel ? int'(s_imm) : int'(y[5:0]);
        r = '0;
        w = '0;
        n = 0;
        case (code)
            1: begin r = x; r[s] = 1'b1; end
            2: begin r = x; r[s] = 1'b0; end
            3: begin r = x; r[s] = ~x[s]; end
            4: r = {63'd0, x[s]};
            5: for (int i = 0; i < 64; i++) r[i] = (i < s) ? 1'b1 : x[i-s];
            6: for (int i = 0; i < 64; i++) r[i] = (i + s > 63) ? 1'b1 : x[i+s];
            7: r = x * 2 + y;
            8: r = x * 4 + y;
            9: r = x * 8 + y;
            10: r = {32'd0, x[31:0]} * 2 + y;
            11: r = {32'd0, x[31:0]} * 4 + y;
            12: r = {32'd0, x[31:0]} * 8 + y;
            13: r = {32'd0, x[31:0]} + y;
            14: begin r[31:0] = x[31:0]; r[63:32] = y[31:0]; end
            15: begin r[31:0] = x[63:32]; r[63:32] = y[63:32]; end
            16: begin r[7:0] = x[7:0]; r[15:8] = y[7:0]; end
            17: begin r[15:0] = x[15:0]; r[31:16] = y[15:0]; r[63:32] = {32{y[15]}}; end
            18: r = sx32({y[31:16], x[31:16]});
            19: begin n = 64; for (int i = 0; i < 64; i++) if (x[i]) n = 63 - i; r = 64'(n); end
            20: begin n = 64; for (int i = 63; i >= 0; i--) if (x[i]) n = i; r = 64'(n); end
            21: begin for (int i = 0; i < 64; i++) n += int'(x[i]); r = 64'(n); end
            22: begin n = 32; for (int i = 0; i < 32; i++) if (x[i]) n = 31 - i; r = 64'(n); end
            23: begin n = 32; for (int i = 31; i >= 0; i--) if (x[i]) n = i; r = 64'(n); end
            24: begin for (int i = 0; i < 32; i++) n += int'(x[i]); r = 64'(n); end
            25: begin for (int i = 0; i < 32; i++) w[(i + s) % 32] = x[i]; r = sx32(w); end
            26: begin for (int i = 0; i < 32; i++) w[i] = x[(i + s) % 32]; r = sx32(w); end
            27: for (int j = 0; j < 8; j++) r[8*j +: 8] = x[8*(7-j) +: 8];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] exp);
        checks++;
        if (res !== exp) begin
            fails++;
            $display("FAIL %s: res=%h expected=%h (op=%0d)", tag, res, exp, op);
        end
    endtask

    // inputs change on the falling edge; result due after the next rising edge
    task automatic run(input int code, input logic [63:0] x, input logic [63:0] y,
                       input logic s_sel, input logic [5:0] s_imm, input string tag);
        op  = 5'(code);
        a   = x;
        b   = y;
        sel = s_sel;
        imm = s_imm;
        @(negedge clk);
        check(tag, model(code, x, y, s_sel, s_imm));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(4.0 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        op = 5'd21;
        a  = '1;
        repeat (3) begin
            @(negedge clk);
            check("R1", 64'd0);
        end
        rst = 1'b0;
        @(negedge clk);
        check("R1", 64'd64);

        run(1, 64'h0, 64'd63, 0, 6'd0, "R2");
        run(2, '1, 64'd0, 0, 6'd0, "R2");
        run(3, 64'h00F0, 64'h0000_0000_0000_0044, 0, 6'd0, "R2");
        run(4, 64'h8000_0000_0000_0000, 64'd127, 0, 6'd0, "R2");
        run(5, 64'h0, 64'd4, 0, 6'd0, "R3");
        run(6, 64'h0, 64'd60, 0, 6'd0, "R3");
        run(9, 64'h1, 64'h10, 0, 6'd0, "R4");
        run(12, 64'hFFFF_FFFF_8000_0000, 64'h1, 0, 6'd0, "R4");
        run(13, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 6'd0, "R4");
        run(14, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 0, 6'd0, "R5");
        run(15, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 0, 6'd0, "R5");
        run(16, 64'hFFFF_FFFF_FFFF_FFAB, 64'hFFFF_FFFF_FFFF_FFCD, 0, 6'd0, "R5");
        run(17, 64'h1234, 64'h8001, 0, 6'd0, "R6");
        run(18, 64'hABCD_0000, 64'h9876_0000, 0, 6'd0, "R6");
        run(19, 64'h0, 64'h0, 0, 6'd0, "R7");
        op = 5'd20; a = 64'h0;
        @(negedge clk);
        check("R7", 64'd64);
        run(21, '1, 64'h0, 0, 6'd0, "R7");
        op = 5'd23; a = 64'hFFFF_FFFF_0000_0000;
        @(negedge clk);
        check("R8", 64'd32);
        op = 5'd22; a = 64'h1;
        @(negedge clk);
        check("R8", 64'd31);
        run(24, 64'hFFFF_FFFF_0000_000F, 64'h0, 0, 6'd0, "R8");
        run(25, 64'h8000_0001, 64'd33, 0, 6'd0, "R9");
        run(26, 64'h0000_0001, 64'd1, 0, 6'd0, "R9");
        run(27, 64'h0102_0304_0506_0708, 64'h0, 0, 6'd0, "R10");
        run(1, 64'h0, 64'd5, 1, 6'd40, "R11");
        run(3, 64'h0, 64'd9, 0, 6'd40, "R11");
        run(0, '1, '1, 0, 6'd0, "R12");
        run(30, '1, '1, 1, 6'd7, "R12");

        for (int n = 0; n < 600; n++) begin
            int code;
            logic [63:0] x, y;
            code = int'($urandom % 32);
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            if (n % 7 == 0) x = '0;
            if (n % 11 == 0) x[31:0] = '0;
            run(code, x, y, 1'($urandom % 2), 6'($urandom % 64), tag_of(code));
        end

        rst = 1'b1;
        @(negedge clk);
        check("R1", 64'd0);
        finish_run();
    end
endmodule